// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Interface

This block is the digital front end of a four-channel, 12-bit converter. It is a clocked model of a register path that was once built from level-sensitive latches. A shared 12-bit data bus feeds four channels. Each channel has two register stages. The input stage takes a word from the bus when that channel is selected. The output stage holds the code that the converter would turn into a voltage.

All control pins are active low and are sampled on each rising clock edge. The write strobe qualifies every transfer. Per-channel enables steer the bus word into input stages. A load-all strobe moves every input stage into its output stage at once, so all four channels update together. The bus, the strobes and the output codes are plain levels: no valid/ready handshake exists and no back-pressure applies. A command takes effect at the clock edge where it is seen. A separate asynchronous clear forces every output stage to the mid-scale code. A static mode pin lets two's-complement data be used by inverting the top bit on entry.

Top module: `quad_dac_bus_if`

## Requirements
- R1: When `wr_n` is high at a clock edge and `clr_n` is high, neither stage of any channel changes.
- R2: When `wr_n` is low, `ld_n` is high and `en_n[k]` is low, channel k's input stage takes the bus word. Every channel whose enable is low takes the same word. No output stage changes.
- R3: When `wr_n` and `ld_n` are low and all four `en_n` bits are high, every output stage copies its own input stage at that same edge.
- R4: When `wr_n`, `ld_n` and all four `en_n` bits are low, both stages of every channel take the bus word (transparent mode).
- R5: When `wr_n` and `ld_n` are low and only some enables are low, each enabled channel takes the bus word into both stages. Each other channel copies its input stage into its output stage.
- R6: Driving `clr_n` low sets every output stage to 0x800 at once, without waiting for a clock edge. While `clr_n` is low, all other controls are ignored and the input stages keep their contents.
- R7: After a clear, the output stages hold 0x800 until a command with `wr_n` and `ld_n` both low overwrites them.
- R8: When `twos_mode` is 1, bus bit 11 is inverted before it is stored. The other bits pass unchanged. When `twos_mode` is 0, the bus word is stored as is.
- R9: A synchronous low on `rst_n` sets every input stage to 0x000 and every output stage to 0x800.
- R10: Channel k's output code sits on `code_out[12k+11:12k]`, with bit 11 as the MSB. Codes are offset binary: 0x000 is minus full scale, 0x800 is zero, and 0xFFF is one step below plus full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_n | input | 1 | Asynchronous clear of the output stages to mid-scale, active low |
| wr_n | input | 1 | Write strobe, active low |
| en_n | input | 4 | Per-channel input-stage enables, active low; bit k is channel k |
| ld_n | input | 1 | Load-all strobe, active low |
| twos_mode | input | 1 | 1 = invert bus bit 11 on entry |
| data_in | input | 12 | Shared data bus |
| code_out | output | 48 | Four output codes; channel k in bits 12k+11:12k |

## Verification
Input stages cannot be seen directly. A wrong input stage therefore shows up only at the first load-all after the bad write: it appears on `code_out` one edge after that command. The bench issues load-all commands after writes, after mode changes and after a clear, so that a bad input stage reaches the ports. A wrong output stage shows up on `code_out` one edge after the command that set it. A clear that fails to act shows up at once, before any clock edge.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned N_CH   = 4;

  function automatic logic [CODE_W-1:0] mid_code();
    logic [CODE_W-1:0] m;
    m = '0;
    m[CODE_W-1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dac_bus_front.sv
module dac_bus_front #(
  parameter int unsigned W = 12,
  parameter int unsigned N = 4
) (
  input  logic         wr_n,
  input  logic         ld_n,
  input  logic [N-1:0] en_n,
  input  logic         twos_mode,
  input  logic [W-1:0] bus,
  output logic         wr_act,
  output logic         ld_all,
  output logic [N-1:0] sel,
  output logic [W-1:0] word
);
  // Write strobe qualifies every transfer
  always_comb begin
    wr_act = ~wr_n;
    ld_all = ~wr_n & ~ld_n;
    sel    = ~en_n & {N{~wr_n}};
    word   = bus;
    if (twos_mode) word[W-1] = ~bus[W-1];
  end
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] MID = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         wr_act,
  input  logic         ld_all,
  input  logic         sel,
  input  logic [W-1:0] word,
  output logic [W-1:0] code
);
  logic [W-1:0] in_q;
  logic [W-1:0] conv_q;

  // First stage: the clear leaves it untouched but blocks loading
  always_ff @(posedge clk) begin
    if (!rst_n)             in_q <= '0;
    else if (clr_n && sel)  in_q <= word;
  end

  // Second stage: asynchronous clear to mid-scale
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)       conv_q <= MID;
    else if (!rst_n)  conv_q <= MID;
    else if (ld_all)  conv_q <= sel ? word : in_q;
  end

  assign code = conv_q;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !wr_act |=> ($stable(conv_q) && $stable(in_q)));

  assert_input_load_R2: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    sel |=> (in_q == $past(word)));

  assert_load_copy_R3: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    (ld_all && !sel) |=> (conv_q == $past(in_q)));

  assert_clear_mid_R6: assert property (@(posedge clk)
    !clr_n |-> (conv_q == MID));

  assert_clear_keeps_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> $stable(in_q));

  assert_hold_until_load_R7: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
    !ld_all |=> $stable(conv_q));
endmodule

// File: rtl/quad_dac_bus_if.sv
module quad_dac_bus_if
  import quad_dac_pkg::*;
#(
  parameter int unsigned W = CODE_W,
  parameter int unsigned N = N_CH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr_n,
  input  logic           wr_n,
  input  logic [N-1:0]   en_n,
  input  logic           ld_n,
  input  logic           twos_mode,
  input  logic [W-1:0]   data_in,
  output logic [N*W-1:0] code_out
);
  localparam logic [W-1:0] MID = W'(1) << (W-1);

  logic         wr_act;
  logic         ld_all;
  logic [N-1:0] sel;
  logic [W-1:0] word;

  dac_bus_front #(.W(W), .N(N)) u_front (
    .wr_n(wr_n), .ld_n(ld_n), .en_n(en_n), .twos_mode(twos_mode),
    .bus(data_in), .wr_act(wr_act), .ld_all(ld_all), .sel(sel), .word(word)
  );

  for (genvar k = 0; k < N; k++) begin : g_ch
    dac_channel #(.W(W), .MID(MID)) u_ch (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .wr_act(wr_act), .ld_all(ld_all), .sel(sel[k]), .word(word),
      .code(code_out[k*W +: W])
    );
  end

  // R8: the stored top bit follows the mode pin
  assert_msb_map_R8: assert property (@(posedge clk)
    (word[W-1] == (data_in[W-1] ^ twos_mode)) && (word[W-2:0] == data_in[W-2:0]));
endmodule

// File: tb/sim_quad_dac_bus_if.sv
`timescale 1ns/1ps
module sim_quad_dac_bus_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  en_n = 4'hF;
  logic        ld_n = 1'b1;
  logic        twos_mode = 1'b0;
  logic [11:0] data_in = '0;
  logic [47:0] code_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  quad_dac_bus_if u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .wr_n(wr_n), .en_n(en_n),
    .ld_n(ld_n), .twos_mode(twos_mode), .data_in(data_in), .code_out(code_out)
  );

  // wr, ld, en[3:0], twos, data[11:0], expected code_out[47:0]
  localparam int NV = 12;
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'b1110, 1'b0, 12'h123, 48'h800_800_800_800}, // R2 ch0
    {1'b0, 1'b1, 4'b1101, 1'b0, 12'h456, 48'h800_800_800_800}, // R2 ch1
    {1'b0, 1'b1, 4'b1011, 1'b0, 12'h789, 48'h800_800_800_800}, // R2 ch2
    {1'b0, 1'b1, 4'b0111, 1'b0, 12'hABC, 48'h800_800_800_800}, // R2 ch3
    {1'b1, 1'b0, 4'b0000, 1'b0, 12'hFFF, 48'h800_800_800_800}, // R1 idle
    {1'b0, 1'b0, 4'b1111, 1'b0, 12'h000, 48'hABC_789_456_123}, // R3 R10
    {1'b0, 1'b1, 4'b1100, 1'b0, 12'h5A5, 48'hABC_789_456_123}, // R2 two ch
    {1'b0, 1'b1, 4'b1011, 1'b1, 12'h123, 48'hABC_789_456_123}, // R8 ch2
    {1'b0, 1'b0, 4'b1111, 1'b0, 12'h000, 48'hABC_923_5A5_5A5}, // R3 R8
    {1'b0, 1'b0, 4'b0000, 1'b1, 12'hFFF, 48'h7FF_7FF_7FF_7FF}, // R4 R8
    {1'b0, 1'b0, 4'b0000, 1'b0, 12'h000, 48'h000_000_000_000}, // R4
    {1'b0, 1'b0, 4'b1110, 1'b0, 12'h3C3, 48'h000_000_000_3C3}  // R5
  };

  task automatic check(input logic [47:0] exp, input string req);
    n_run++;
    if (code_out !== exp) begin
      n_fail++;
      $display("FAIL %s: code_out=%h expected=%h", req, code_out, exp);
    end
  endtask

  task automatic drive(input logic w, input logic l, input logic [3:0] e,
                       input logic t, input logic [11:0] d);
    wr_n = w; ld_n = l; en_n = e; twos_mode = t; data_in = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(48'h800_800_800_800, "R9");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][66], VEC[i][65], VEC[i][64:61], VEC[i][60], VEC[i][59:48]);
      @(negedge clk);
      check(VEC[i][47:0], $sformatf("R1-R5 vector %0d", i));
    end
    drive(1'b1, 1'b1, 4'hF, 1'b0, 12'h000);
    @(negedge clk);

    // R6: the clear acts between edges
    #1 clr_n = 1'b0;
    #0.5 check(48'h800_800_800_800, "R6 async");
    // R6: a write and a load during the clear are ignored
    drive(1'b0, 1'b0, 4'b0000, 1'b0, 12'h111);
    @(negedge clk);
    check(48'h800_800_800_800, "R6 controls ignored");
    drive(1'b1, 1'b1, 4'hF, 1'b0, 12'h000);
    clr_n = 1'b1;
    @(negedge clk);
    // R7: a write to inputs only keeps mid-scale
    drive(1'b0, 1'b1, 4'b0111, 1'b0, 12'h654);
    @(negedge clk);
    check(48'h800_800_800_800, "R7 hold after clear");
    // R6 + R7: load-all shows inputs kept across the clear
    drive(1'b0, 1'b0, 4'b1111, 1'b0, 12'h000);
    @(negedge clk);
    check(48'h654_000_000_3C3, "R6 R7 inputs kept");

    // R9: synchronous reset zeroes inputs and sets mid-scale
    drive(1'b1, 1'b1, 4'hF, 1'b0, 12'h000);
    rst_n = 1'b0;
    @(negedge clk);
    check(48'h800_800_800_800, "R9 reset");
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 4'b1111, 1'b0, 12'hFFF);
    @(negedge clk);
    check(48'h000_000_000_000, "R9 inputs zeroed");

    // R8: two's-complement minus one maps to 0x7FF, zero to 0x800
    drive(1'b0, 1'b0, 4'b1110, 1'b1, 12'h000);
    @(negedge clk);
    check(48'h000_000_000_800, "R8 R10 zero");
    drive(1'b1, 1'b1, 4'hF, 1'b0, 12'h000);
    @(negedge clk);
    finish_run();
  end
endmodule